// File: doc/BRIEF.md
# Root Port Error Collector

This block keeps the root-level error status and the root error enable set of a PCI Express root port. Each incoming error message carries a one-hot severity and a requester identity, which is a bus number and a device/function number. For each message the block sets the received flag of its class. It records whether a second message of a class arrived, notes whether a fatal error was the first uncorrectable one, and captures the requester identity of the first correctable and the first uncorrectable message.

Software reaches the block through three strobes. One writes the enable set, one clears status flags by write-one-to-clear, and one loads a read-only interrupt message number. The enabled condition is true when any received flag has its matching enable set. In message-signalled mode the block raises a one-cycle notify pulse when that condition changes from false to true. In legacy mode it drives a level interrupt that follows the condition. Configuration decode and the sending of the interrupt message are done elsewhere.

Top module: `root_err_collector`

## Requirements
- R1: While `rst` is high at a clock edge, the enable set, all status flags, both source registers, the message number, `intx` and `notify` are zero after that edge.
- R2: A correctable message (`msg_sev`=3'b001) sets status bit 0. If bit 0 was already set, it sets bit 1 and leaves `cor_src` unchanged. Otherwise it loads `cor_src` with the requester identity.
- R3: A non-fatal (3'b010) or fatal (3'b100) message sets status bit 2. If bit 2 was already set, it sets bit 3 and leaves `unc_src` unchanged. Otherwise it loads `unc_src`. A non-fatal message also sets bit 5, and a fatal message also sets bit 6.
- R4: A fatal message sets status bit 4 only when status bit 2 was clear before that message.
- R5: A `sts_clr` strobe clears every status bit that is set in `sts_clr_mask`. A message in the same cycle is applied to the already-cleared flags.
- R6: A message whose severity is not exactly one-hot changes no status flag and no source register.
- R7: When `msi_mode` is 1, `notify` is high for exactly one cycle, the cycle after an edge at which the enabled condition goes from false to true. This holds whether a message or a write of the enable set caused the change. The enabled condition is (en[0]&bit0)|(en[1]&bit5)|(en[2]&bit6).
- R8: When `msi_mode` is 0, `intx` equals the enabled condition of the state after each edge. When `msi_mode` is 1, `intx` is 0.
- R9: `vec_num` changes only on a `vec_load` strobe, which loads `vec_in`.
- R10: A captured source equals {`msg_bus`, `msg_devfn`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Error message strobe |
| msg_sev | input | 3 | Severity, one-hot: bit0 correctable, bit1 non-fatal, bit2 fatal |
| msg_bus | input | 8 | Requester bus number |
| msg_devfn | input | 8 | Requester device/function number |
| en_we | input | 1 | Enable-set write strobe |
| en_wdata | input | 3 | New enables: bit0 correctable, bit1 non-fatal, bit2 fatal |
| sts_clr | input | 1 | Status clear strobe |
| sts_clr_mask | input | 7 | Status bits to clear |
| vec_load | input | 1 | Message number load strobe |
| vec_in | input | 5 | Message number to load |
| msi_mode | input | 1 | 1: pulse notification, 0: legacy level |
| root_en | output | 3 | Current enable set |
| root_sts | output | 7 | Status flags |
| cor_src | output | 16 | First correctable requester identity |
| unc_src | output | 16 | First uncorrectable requester identity |
| vec_num | output | 5 | Interrupt message number |
| intx | output | 1 | Legacy interrupt level |
| notify | output | 1 | One-cycle notification pulse |

## Verification
The bench sends repeated messages of one class and checks that the first source is kept and the multiple flag is set. A design that overwrote the source register would show the later requester. It sends a fatal message after a non-fatal one and checks that the first-fatal flag stays clear. It clears a flag and sends a message in the same cycle, so a design that applied the clear last would lose the new flag. It also sends malformed severities, writes enables while the condition is already true, and switches between interrupt modes. A design that pulsed on a level, or re-notified on every message, would put an extra `notify` against the model.

// File: rtl/rec_pkg.sv
package rec_pkg;
  localparam int STS_W  = 7;
  localparam int SEV_W  = 3;
  localparam int ST_COR  = 0;
  localparam int ST_MCOR = 1;
  localparam int ST_UNC  = 2;
  localparam int ST_MUNC = 3;
  localparam int ST_FF   = 4;
  localparam int ST_NF   = 5;
  localparam int ST_FAT  = 6;
  localparam int SV_COR = 0;
  localparam int SV_NF  = 1;
  localparam int SV_FAT = 2;
  typedef logic [STS_W-1:0] sts_t;
  typedef logic [SEV_W-1:0] sev_t;

  function automatic logic enabled_cond(sts_t s, sev_t en);
    return (en[SV_COR] & s[ST_COR]) | (en[SV_NF] & s[ST_NF]) |
           (en[SV_FAT] & s[ST_FAT]);
  endfunction
endpackage

// File: rtl/rec_flag_logic.sv
module rec_flag_logic
  import rec_pkg::*;
(
  input  sts_t sts_q,
  input  sts_t clr_mask,
  input  logic msg_valid,
  input  sev_t msg_sev,
  output sts_t sts_next,
  output logic cap_cor,
  output logic cap_unc
);
  sts_t base;
  logic ok;

  always_comb begin
    base     = sts_q & ~clr_mask;
    ok       = msg_valid && (msg_sev == 3'b001 || msg_sev == 3'b010 || msg_sev == 3'b100);
    sts_next = base;
    cap_cor  = 1'b0;
    cap_unc  = 1'b0;
    if (ok) begin
      if (msg_sev[SV_COR]) begin
        if (base[ST_COR]) sts_next[ST_MCOR] = 1'b1;
        else              cap_cor = 1'b1;
        sts_next[ST_COR] = 1'b1;
      end
      if (msg_sev[SV_NF]) sts_next[ST_NF] = 1'b1;
      if (msg_sev[SV_FAT]) begin
        if (!base[ST_UNC]) sts_next[ST_FF] = 1'b1;
        sts_next[ST_FAT] = 1'b1;
      end
      if (msg_sev[SV_NF] || msg_sev[SV_FAT]) begin
        if (base[ST_UNC]) sts_next[ST_MUNC] = 1'b1;
        else              cap_unc = 1'b1;
        sts_next[ST_UNC] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rec_src_reg.sv
module rec_src_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/rec_irq_ctrl.sv
module rec_irq_ctrl
  import rec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic msi_mode,
  input  sts_t sts_q,
  input  sev_t en_q,
  input  sts_t sts_next,
  input  sev_t en_next,
  output logic intx,
  output logic notify
);
  logic cond_prev, cond_new;

  always_comb begin
    cond_prev = enabled_cond(sts_q, en_q);
    cond_new  = enabled_cond(sts_next, en_next);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intx   <= 1'b0;
      notify <= 1'b0;
    end else begin
      intx   <= !msi_mode && cond_new;
      notify <= msi_mode && cond_new && !cond_prev;
    end
  end

  assert_notify_single_R7: assert property (@(posedge clk) disable iff (rst)
    notify |=> !notify);
  assert_msi_no_intx_R8: assert property (@(posedge clk) disable iff (rst)
    msi_mode |=> !intx);
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import rec_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int VEC_W   = 5,
  localparam int SRC_W  = BUS_W + DEVFN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               msg_valid,
  input  logic [2:0]         msg_sev,
  input  logic [BUS_W-1:0]   msg_bus,
  input  logic [DEVFN_W-1:0] msg_devfn,
  input  logic               en_we,
  input  logic [2:0]         en_wdata,
  input  logic               sts_clr,
  input  logic [6:0]         sts_clr_mask,
  input  logic               vec_load,
  input  logic [VEC_W-1:0]   vec_in,
  input  logic               msi_mode,
  output logic [2:0]         root_en,
  output logic [6:0]         root_sts,
  output logic [SRC_W-1:0]   cor_src,
  output logic [SRC_W-1:0]   unc_src,
  output logic [VEC_W-1:0]   vec_num,
  output logic               intx,
  output logic               notify
);
  sts_t sts_q, sts_next, clr_mask;
  sev_t en_q, en_next;
  logic cap_cor, cap_unc;
  logic [SRC_W-1:0] req_id;

  assign clr_mask = sts_clr ? sts_clr_mask : '0;
  assign en_next  = en_we ? en_wdata : en_q;
  assign req_id   = {msg_bus, msg_devfn};

  rec_flag_logic u_flags (
    .sts_q(sts_q), .clr_mask(clr_mask), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .sts_next(sts_next), .cap_cor(cap_cor), .cap_unc(cap_unc)
  );

  for (genvar g = 0; g < 2; g++) begin : g_src
    logic [SRC_W-1:0] q;
    rec_src_reg #(.W(SRC_W)) u_src (
      .clk(clk), .rst(rst), .cap(g == 0 ? cap_cor : cap_unc), .d(req_id), .q(q)
    );
  end
  assign cor_src = g_src[0].q;
  assign unc_src = g_src[1].q;

  rec_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .msi_mode(msi_mode), .sts_q(sts_q), .en_q(en_q),
    .sts_next(sts_next), .en_next(en_next), .intx(intx), .notify(notify)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q   <= '0;
      en_q    <= '0;
      vec_num <= '0;
    end else begin
      sts_q <= sts_next;
      en_q  <= en_next;
      if (vec_load) vec_num <= vec_in;
    end
  end

  assign root_en  = en_q;
  assign root_sts = sts_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (root_en == 3'b000 && root_sts == 7'b0 && !notify));
  assert_multi_cor_R2: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_sev == 3'b001 && root_sts[ST_COR] && !(sts_clr && sts_clr_mask[ST_COR]))
    |=> (root_sts[ST_MCOR] && $stable(cor_src)));
  assert_unc_src_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (root_sts[ST_UNC] && !(sts_clr && sts_clr_mask[ST_UNC])) |=> $stable(unc_src));
  assert_bad_sev_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !$onehot(msg_sev) && !sts_clr) |=> ($stable(root_sts) && $stable(cor_src)));
  assert_vec_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !vec_load |=> $stable(vec_num));
endmodule

// File: tb/root_err_collector_test.sv
module root_err_collector_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic msg_valid = 0; logic [2:0] msg_sev = 0;
  logic [7:0] msg_bus = 0, msg_devfn = 0;
  logic en_we = 0; logic [2:0] en_wdata = 0;
  logic sts_clr = 0; logic [6:0] sts_clr_mask = 0;
  logic vec_load = 0; logic [4:0] vec_in = 0;
  logic msi_mode = 0;
  logic [2:0] root_en; logic [6:0] root_sts;
  logic [15:0] cor_src, unc_src; logic [4:0] vec_num;
  logic intx, notify;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // model state
  logic [2:0] m_en; logic [6:0] m_sts; logic [15:0] m_cor, m_unc;
  logic [4:0] m_vec; logic m_intx, m_notify;

  root_err_collector uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual cycles=%0d expected <=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic cond(logic [6:0] s, logic [2:0] e);
    return (e[0] & s[0]) | (e[1] & s[5]) | (e[2] & s[6]);
  endfunction

  task automatic model_step();
    logic [6:0] b, n; logic [2:0] ne; logic pc;
    if (rst) begin
      m_en = 0; m_sts = 0; m_cor = 0; m_unc = 0; m_vec = 0; m_intx = 0; m_notify = 0;
      return;
    end
    pc = cond(m_sts, m_en);
    b  = sts_clr ? (m_sts & ~sts_clr_mask) : m_sts;
    n  = b;
    ne = en_we ? en_wdata : m_en;
    if (msg_valid && $countones(msg_sev) == 1) begin
      if (msg_sev == 3'b001) begin
        if (b[0]) n[1] = 1; else m_cor = {msg_bus, msg_devfn};
        n[0] = 1;
      end else begin
        if (msg_sev == 3'b100) begin n[6] = 1; if (!b[2]) n[4] = 1; end
        else n[5] = 1;
        if (b[2]) n[3] = 1; else m_unc = {msg_bus, msg_devfn};
        n[2] = 1;
      end
    end
    if (vec_load) m_vec = vec_in;
    m_sts = n; m_en = ne;
    m_notify = msi_mode && cond(n, ne) && !pc;
    m_intx   = !msi_mode && cond(n, ne);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R3 status", root_sts, m_sts);
    chk("R2 cor_src", cor_src, m_cor);
    chk("R10 unc_src", unc_src, m_unc);
    chk("R7 notify", notify, m_notify);
    chk("R8 intx", intx, m_intx);
    chk("R9 vec", vec_num, m_vec);
    chk("R1 enables", root_en, m_en);
  endtask

  task automatic idle_in();
    msg_valid = 0; en_we = 0; sts_clr = 0; vec_load = 0;
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all();
    idle_in();
  endtask

  task automatic send(logic [2:0] s, logic [7:0] b, logic [7:0] d);
    msg_valid = 1; msg_sev = s; msg_bus = b; msg_devfn = d;
  endtask

  initial begin
    @(negedge clk);
    rst = 1; step(); step();
    chk("R1 reset status", root_sts, 7'h00);
    chk("R1 reset notify", notify, 1'b0);
    rst = 0;
    // message-signalled mode
    msi_mode = 1; en_we = 1; en_wdata = 3'b111; step();
    send(3'b001, 8'h03, 8'h11); step();
    chk("R10 first cor src", cor_src, 16'h0311);
    chk("R7 pulse on first cor", notify, 1'b1);
    send(3'b001, 8'h44, 8'h55); step();
    chk("R2 multi cor", root_sts[1], 1'b1);
    chk("R2 src kept", cor_src, 16'h0311);
    chk("R7 no repeat pulse", notify, 1'b0);
    send(3'b010, 8'h07, 8'h08); step();
    chk("R3 nonfatal src", unc_src, 16'h0708);
    send(3'b100, 8'h09, 8'h0a); step();
    chk("R4 no first fatal after nonfatal", root_sts[4], 1'b0);
    chk("R3 multi unc", root_sts[3], 1'b1);
    sts_clr = 1; sts_clr_mask = 7'h7f; step();
    chk("R5 all cleared", root_sts, 7'h00);
    send(3'b100, 8'h0b, 8'h0c); step();
    chk("R4 first fatal", root_sts[4], 1'b1);
    send(3'b011, 8'hff, 8'hff); step();
    chk("R6 bad sev ignored", root_sts, 7'h54);
    send(3'b000, 8'hff, 8'hff); step();
    chk("R6 zero sev ignored", unc_src, 16'h0b0c);
    // clear and set in same cycle
    send(3'b001, 8'h20, 8'h21); step();
    sts_clr = 1; sts_clr_mask = 7'h03; send(3'b001, 8'h22, 8'h23); step();
    chk("R5 clear before set", root_sts[1:0], 2'b01);
    chk("R5 src recaptured", cor_src, 16'h2223);
    // enable write causing rise
    en_we = 1; en_wdata = 3'b000; step();
    en_we = 1; en_wdata = 3'b001; step();
    chk("R7 pulse on enable write", notify, 1'b1);
    // legacy mode
    msi_mode = 0; step();
    chk("R8 legacy level", intx, 1'b1);
    sts_clr = 1; sts_clr_mask = 7'h01; step();
    chk("R8 level drops", intx, 1'b0);
    vec_load = 1; vec_in = 5'h1a; step();
    send(3'b100, 8'h01, 8'h02); step();
    chk("R9 vec held", vec_num, 5'h1a);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      msg_valid = r[0] | r[1];
      msg_sev   = (r[4:2] == 0) ? 3'b011 : (3'b001 << (r[6:5] % 3));
      msg_bus   = $urandom; msg_devfn = $urandom;
      en_we     = (r[9:7] == 0); en_wdata = r[12:10];
      sts_clr   = (r[15:13] == 0); sts_clr_mask = r[22:16];
      vec_load  = (r[26:23] == 0); vec_in = r[31:27];
      if (r[30:24] == 0) msi_mode = ~msi_mode;
      rst = ($urandom_range(0, 999) == 0);
      step();
      rst = 0;
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
  end
endmodule